// File: doc/BRIEF.md
# Edge-Triggered Dual Capture Timer

This block is one timer channel used to measure the time between events on an input pin. A counter advances once per clock-enable tick while the channel runs. On chosen edges of pin A, the current count goes into capture register A and then into capture register B. The two values give a period or a pulse width without help from software. Loads always come in pairs: register B accepts a value only once A has taken one, and each B load arms A again.

Sticky status flags record six events: counter wrap, a load that overwrote an unread value, a match against a compare value, each of the two loads, and an external trigger. All flags clear when the status is read. An edge on pin A or pin B can act as an external trigger, which restarts the count and re-arms the capture sequence. A compare value can also bound the count. After the B load the channel can either freeze the count until the next trigger or switch its clock off until software starts it again.

Top module: `cap_timer`

## Requirements
- R1: After reset the count, both capture registers and all status bits are zero, and the clock is switched off, so ticks do not advance the count until `sw_start` is pulsed.
- R2: While running, every cycle with `tick` high adds one to `count`, modulo 2^CNT_W. With `tick` low and no restart, `count` holds.
- R3: When the count steps from all ones to zero, status bit 0 is set.
- R4: `mode[1:0]` selects the pin A edge that loads register A (0 none, 1 rising, 2 falling, 3 both). The load happens only while A is armed (after reset, start, trigger or a B load), stores `count`, and sets status bit 5.
- R5: `mode[3:2]` selects, with the same encoding, the pin A edge that loads register B. B loads only after A has loaded, sets status bit 6, and re-arms A. An edge that matches only B's code while A is armed loads nothing.
- R6: A load into A or B while the previous value of that register is still unread (`rd_a` / `rd_b` not pulsed since) sets status bit 1.
- R7: With `mode[8]` set, a B load freezes the count. The next external trigger or start clears the count and resumes counting.
- R8: With `mode[9]` set, a B load switches the clock off. Ticks, pin edges and external triggers do not start it again (a trigger still clears the count); only `sw_start` does.
- R9: `mode[5:4]` selects the trigger edge (same encoding), and `mode[6]` takes it from pin B (1) or pin A (0). A trigger clears the count, re-arms A and sets status bit 7.
- R10: A tick while `count` equals `rc` sets status bit 4. With `mode[7]` set, that tick loads zero instead of incrementing, so the count runs 0..rc, and no wrap flag is raised.
- R11: Status bits stay set until `rd_status` is pulsed, which clears them. An event in the same cycle wins over the clear. Bits 2 and 3 read zero.
- R12: `sw_start` switches the clock on, clears the count and re-arms A without setting any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| sw_start | input | 1 | Pulse: enable clock, clear count, arm A |
| pin_a | input | 1 | Asynchronous capture/trigger pin |
| pin_b | input | 1 | Asynchronous trigger pin |
| mode | input | 10 | Channel mode word (fields in R4, R5, R7-R10) |
| rc | input | CNT_W | Compare value |
| rd_a | input | 1 | Pulse: register A has been read |
| rd_b | input | 1 | Pulse: register B has been read |
| rd_status | input | 1 | Pulse: status read, clears flags |
| count | output | CNT_W | Current counter value |
| reg_a | output | CNT_W | Capture register A |
| reg_b | output | CNT_W | Capture register B |
| status | output | 8 | Sticky event flags |

## Verification
The bench builds the channel with CNT_W = 4, so the count wraps after sixteen ticks. This brings overflow and compare-reset sequences within a few dozen cycles. Every edge code of the A field, the B field and the trigger field is swept against both pin directions, and the expected load or restart comes from the code bits. Capture values are set by explicit tick counts, so each expected register value is a plain sum.

// File: rtl/ct_pkg.sv
package ct_pkg;

  // Channel mode word, MSB first (bit 9 down to bit 0).
  typedef struct packed {
    logic       dis_on_b;
    logic       stop_on_b;
    logic       rc_rst_en;
    logic       trig_on_b;
    logic [1:0] trig_edge;
    logic [1:0] b_edge;
    logic [1:0] a_edge;
  } ct_mode_t;

  localparam int MODE_W = $bits(ct_mode_t);
  localparam int STAT_W = 8;

  // Status bit positions.
  localparam int ST_OVF = 0;
  localparam int ST_OVR = 1;
  localparam int ST_CMP = 4;
  localparam int ST_LDA = 5;
  localparam int ST_LDB = 6;
  localparam int ST_TRG = 7;

  // Edge code: bit 0 enables rising, bit 1 enables falling.
  function automatic logic edge_hit(input logic [1:0] code,
                                    input logic rise, input logic fall);
    return (code[0] & rise) | (code[1] & fall);
  endfunction

endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise =  chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
  assign fall = ~chain_q[CHAIN-2] &  chain_q[CHAIN-1];
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sw_start,
  input  logic             trig,
  input  logic             halt_req,
  input  logic             dis_req,
  input  logic             rc_rst_en,
  input  logic [CNT_W-1:0] rc,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             ovf_ev,
  output logic             cmp_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clk_on_q, clk_on_d;
  logic             stopped_q, stopped_d;
  logic             restart, step, match, wrap_rc;

  always_comb begin
    restart = sw_start | trig;
    step    = tick & run & ~restart;
    match   = (cnt_q == rc);
    wrap_rc = rc_rst_en & match;

    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (step) cnt_d = wrap_rc ? '0 : cnt_q + 1'b1;

    stopped_d = stopped_q;
    if (restart)       stopped_d = 1'b0;
    else if (halt_req) stopped_d = 1'b1;

    clk_on_d = clk_on_q;
    if (sw_start)     clk_on_d = 1'b1;
    else if (dis_req) clk_on_d = 1'b0;

    ovf_ev = step & ~wrap_rc & (cnt_q == CNT_MAX);
    cmp_ev = step & match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      clk_on_q  <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      clk_on_q  <= clk_on_d;
      stopped_q <= stopped_d;
    end
  end

  assign run = clk_on_q & ~stopped_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/ct_capture.sv
module ct_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             a_hit,
  input  logic             b_hit,
  input  logic             rd_a,
  input  logic             rd_b,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] reg_a,
  output logic [CNT_W-1:0] reg_b,
  output logic             load_a,
  output logic             load_b,
  output logic             ovr_ev
);
  logic [CNT_W-1:0] ra_q, ra_d, rb_q, rb_d;
  logic             wait_b_q, wait_b_d;
  logic             a_new_q, a_new_d, b_new_q, b_new_d;

  always_comb begin
    load_a = run & ~restart & ~wait_b_q & a_hit;
    load_b = run & ~restart &  wait_b_q & b_hit;

    ra_d = load_a ? cnt : ra_q;
    rb_d = load_b ? cnt : rb_q;

    wait_b_d = wait_b_q;
    if (restart)     wait_b_d = 1'b0;
    else if (load_a) wait_b_d = 1'b1;
    else if (load_b) wait_b_d = 1'b0;

    a_new_d = a_new_q;
    if (load_a)    a_new_d = 1'b1;
    else if (rd_a) a_new_d = 1'b0;

    b_new_d = b_new_q;
    if (load_b)    b_new_d = 1'b1;
    else if (rd_b) b_new_d = 1'b0;

    ovr_ev = (load_a & a_new_q) | (load_b & b_new_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q     <= '0;
      rb_q     <= '0;
      wait_b_q <= 1'b0;
      a_new_q  <= 1'b0;
      b_new_q  <= 1'b0;
    end else begin
      ra_q     <= ra_d;
      rb_q     <= rb_d;
      wait_b_q <= wait_b_d;
      a_new_q  <= a_new_d;
      b_new_q  <= b_new_d;
    end
  end

  assign reg_a = ra_q;
  assign reg_b = rb_q;
endmodule

// File: rtl/ct_status.sv
module ct_status #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] ev,
  input  logic             rd_clr,
  output logic [NBITS-1:0] flags
);
  logic [NBITS-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               sw_start,
  input  logic               pin_a,
  input  logic               pin_b,
  input  logic [MODE_W-1:0]  mode,
  input  logic [CNT_W-1:0]   rc,
  input  logic               rd_a,
  input  logic               rd_b,
  input  logic               rd_status,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   reg_a,
  output logic [CNT_W-1:0]   reg_b,
  output logic [STAT_W-1:0]  status
);
  localparam int NPIN = 2;

  ct_mode_t          cfg;
  logic [NPIN-1:0]   pins, rise, fall;
  logic              trig_hit, a_hit, b_hit, run;
  logic              load_a, load_b, ovr_ev, ovf_ev, cmp_ev;
  logic [STAT_W-1:0] ev;

  assign cfg  = ct_mode_t'(mode);
  assign pins = {pin_b, pin_a};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    ct_edge_sync #(.SYNC_STAGES(2)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .pin (pins[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  always_comb begin
    a_hit    = edge_hit(cfg.a_edge, rise[0], fall[0]);
    b_hit    = edge_hit(cfg.b_edge, rise[0], fall[0]);
    trig_hit = cfg.trig_on_b ? edge_hit(cfg.trig_edge, rise[1], fall[1])
                             : edge_hit(cfg.trig_edge, rise[0], fall[0]);
  end

  ct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick),
    .sw_start (sw_start),
    .trig (trig_hit),
    .halt_req (load_b & cfg.stop_on_b),
    .dis_req (load_b & cfg.dis_on_b),
    .rc_rst_en (cfg.rc_rst_en),
    .rc (rc),
    .cnt (count),
    .run (run),
    .ovf_ev (ovf_ev),
    .cmp_ev (cmp_ev)
  );

  ct_capture #(.CNT_W(CNT_W)) u_capture (
    .clk (clk),
    .rst_n (rst_n),
    .run (run),
    .restart (sw_start | trig_hit),
    .a_hit (a_hit),
    .b_hit (b_hit),
    .rd_a (rd_a),
    .rd_b (rd_b),
    .cnt (count),
    .reg_a (reg_a),
    .reg_b (reg_b),
    .load_a (load_a),
    .load_b (load_b),
    .ovr_ev (ovr_ev)
  );

  always_comb begin
    ev         = '0;
    ev[ST_OVF] = ovf_ev;
    ev[ST_OVR] = ovr_ev;
    ev[ST_CMP] = cmp_ev;
    ev[ST_LDA] = load_a;
    ev[ST_LDB] = load_b;
    ev[ST_TRG] = trig_hit;
  end

  ct_status #(.NBITS(STAT_W)) u_status (
    .clk (clk),
    .rst_n (rst_n),
    .ev (ev),
    .rd_clr (rd_status),
    .flags (status)
  );
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             sw_start,
  input logic             rd_status,
  input logic             trig_hit,
  input logic             load_b,
  input logic             ovr_ev,
  input logic [CNT_W-1:0] count,
  input logic [7:0]       status
);
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_start && !trig_hit) |=> (count == $past(count)));

  a_r12_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |=> (count == '0));

  a_r9_trigger_restart: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> (count == '0 && status[7]));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_status |=> ((status & $past(status)) == $past(status)));

  a_r5_b_flag: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |=> status[6]);

  a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> status[1]);
endmodule

bind cap_timer ct_checker #(.CNT_W(CNT_W)) u_ct_checker (
  .clk (clk),
  .rst_n (rst_n),
  .tick (tick),
  .sw_start (sw_start),
  .rd_status (rd_status),
  .trig_hit (trig_hit),
  .load_b (load_b),
  .ovr_ev (ovr_ev),
  .count (count),
  .status (status)
);

// File: tb/test_cap_timer.sv
module test_cap_timer;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n, tick, sw_start, pin_a, pin_b, rd_a, rd_b, rd_status;
  logic [9:0]   mode;
  logic [W-1:0] rc;
  logic [W-1:0] count, reg_a, reg_b;
  logic [7:0]   status;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cap_timer #(.CNT_W(W)) i_cap_timer (
    .clk (clk), .rst_n (rst_n), .tick (tick), .sw_start (sw_start),
    .pin_a (pin_a), .pin_b (pin_b), .mode (mode), .rc (rc),
    .rd_a (rd_a), .rd_b (rd_b), .rd_status (rd_status),
    .count (count), .reg_a (reg_a), .reg_b (reg_b), .status (status)
  );

  function automatic logic [9:0] md(input logic [1:0] ae, input logic [1:0] be,
                                    input logic [1:0] te, input logic tsel,
                                    input logic rce, input logic stp, input logic dis);
    return {dis, stp, rce, tsel, te, be, ae};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start();
    sw_start = 1'b1; cyc(1); sw_start = 1'b0;
  endtask

  task automatic clr();
    rd_status = 1'b1; rd_a = 1'b1; rd_b = 1'b1; cyc(1);
    rd_status = 1'b0; rd_a = 1'b0; rd_b = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1; cyc(n); tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(2.5 * 2 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; sw_start = 1'b0; pin_a = 1'b0; pin_b = 1'b0;
    rd_a = 1'b0; rd_b = 1'b0; rd_status = 1'b0; mode = '0; rc = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1", "status", status, 0);
    chk("R1", "count", count, 0);
    chk("R1", "reg_a", reg_a, 0);
    chk("R1", "reg_b", reg_b, 0);
    ticks(3);
    chk("R1", "count before start", count, 0);

    // R12 start, R2 counting
    start();
    chk("R12", "start status", status, 0);
    ticks(7);
    chk("R2", "count after 7", count, 7);
    cyc(3);
    chk("R2", "count holds", count, 7);

    // R3 overflow
    start(); clr();
    ticks(15);
    chk("R3", "no wrap yet", status[0], 0);
    ticks(1);
    chk("R3", "wrap flag", status[0], 1);
    chk("R3", "wrapped count", count, 0);
    cyc(4);
    chk("R11", "flag sticky", status[0], 1);
    clr();
    chk("R11", "clear on read", status, 0);

    // R4 sweep of A edge code against both directions
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        logic [1:0] cc;
        int k, ld;
        cc = 2'(c);
        k = c * 2 + d + 1;
        mode = '0; pin_a = d[0]; cyc(4);
        mode = md(cc, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        start(); clr();
        ticks(k);
        pin_a = ~d[0]; cyc(4);
        ld = d ? int'(cc[1]) : int'(cc[0]);
        chk("R4", "A load flag", status[5], ld);
        if (ld != 0) chk("R4", "A value", reg_a, k);
      end
    end

    // R5 sweep of B edge code; A loads on any edge first
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        logic [1:0] cc;
        int ld;
        cc = 2'(c);
        mode = '0; pin_a = d[0]; cyc(4);
        mode = md(2'd3, cc, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        start(); clr();
        ticks(2);
        pin_a = ~d[0]; cyc(4);
        chk("R5", "A before B", reg_a, 2);
        ticks(3);
        pin_a = d[0]; cyc(4);
        ld = d ? int'(cc[0]) : int'(cc[1]);
        chk("R5", "B load flag", status[6], ld);
        if (ld != 0) chk("R5", "B value", reg_b, 5);
      end
    end

    // R5 B edge while A armed loads nothing
    mode = '0; pin_a = 1'b0; cyc(4);
    mode = md(2'd2, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    start(); clr();
    pin_a = 1'b1; cyc(4);
    chk("R5", "no B before A", status[6], 0);
    chk("R5", "no A on rising", status[5], 0);

    // R6 overrun
    mode = md(2'd3, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    start(); clr();
    pin_a = ~pin_a; cyc(4);
    pin_a = ~pin_a; cyc(4);
    chk("R6", "no overrun yet", status[1], 0);
    pin_a = ~pin_a; cyc(4);
    chk("R6", "A reload unread", status[1], 1);
    clr();
    pin_a = ~pin_a; cyc(4);
    chk("R6", "B after read", status[1], 0);

    // R7 stop on B load, restart by trigger from pin B
    pin_b = 1'b0;
    mode = md(2'd3, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    cyc(4);
    start(); clr();
    ticks(1);
    pin_a = ~pin_a; cyc(4);
    ticks(1);
    pin_a = ~pin_a; cyc(4);
    chk("R7", "B value", reg_b, 2);
    ticks(5);
    chk("R7", "frozen", count, 2);
    pin_b = 1'b1; cyc(4);
    chk("R9", "trigger clears", count, 0);
    chk("R9", "trigger flag", status[7], 1);
    ticks(3);
    chk("R7", "resumed", count, 3);

    // R8 disable on B load
    mode = md(2'd3, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    start(); clr();
    ticks(1);
    pin_a = ~pin_a; cyc(4);
    ticks(1);
    pin_a = ~pin_a; cyc(4);
    ticks(5);
    chk("R8", "frozen", count, 2);
    pin_b = ~pin_b; cyc(4);
    chk("R8", "trigger clears", count, 0);
    ticks(3);
    chk("R8", "still off", count, 0);
    clr();
    pin_a = ~pin_a; cyc(4);
    chk("R8", "edges ignored", status[5], 0);
    start();
    ticks(2);
    chk("R8", "start re-enables", count, 2);

    // R9 trigger code sweep on pin B
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        logic [1:0] cc;
        int hit;
        cc = 2'(c);
        mode = '0; pin_b = d[0]; cyc(4);
        mode = md(2'd0, 2'd0, cc, 1'b1, 1'b0, 1'b0, 1'b0);
        start(); clr();
        ticks(6);
        pin_b = ~d[0]; cyc(4);
        hit = d ? int'(cc[1]) : int'(cc[0]);
        chk("R9", "trigger flag", status[7], hit);
        chk("R9", "count", count, hit ? 0 : 6);
      end
    end

    // R9 pin select: trigger from pin A ignores pin B
    mode = md(2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    start(); clr();
    ticks(4);
    pin_b = ~pin_b; cyc(4);
    chk("R9", "pin B ignored", count, 4);
    pin_a = ~pin_a; cyc(4);
    chk("R9", "pin A triggers", count, 0);

    // R10 compare with and without reset
    rc = 4'd5;
    mode = md(2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    start(); clr();
    ticks(4);
    chk("R10", "no match yet", status[4], 0);
    ticks(6);
    chk("R10", "bounded count", count, 10 % 6);
    chk("R10", "compare flag", status[4], 1);
    ticks(20);
    chk("R10", "no wrap flag", status[0], 0);
    mode = '0;
    start(); clr();
    ticks(20);
    chk("R10", "free count", count, 20 % 16);
    chk("R10", "compare flag free", status[4], 1);
    chk("R3", "wrap flag free", status[0], 1);
    chk("R11", "reserved bits", status[3:2], 0);

    finish_run();
  end
endmodule